// File: doc/BRIEF.md
# CPU Memory Bus Interface

This block connects an 8-bit CPU core with a 16-bit address space to a narrow pin set. It sorts every CPU access into one of three targets. The lower half of the address space goes to external memory. The upper half reads a built-in 256-byte test ROM, which repeats every 256 bytes. One address in the upper half, 0xFF00, also acts as a write-only 8-bit audio level register. Reads from the CPU are combinational: the read byte is valid in the same cycle the address is presented.

Only eight shared pins carry the low address byte, so the block reuses them for the outgoing store byte during the execute and writeback phases of a store. While that happens, external hardware sees only the seven high address bits. A further eight output pins carry address bits [14:8] and an active-low write strobe. The bus has no back-pressure. The CPU owns the timing through its phase code, and every access finishes in the cycle it is presented. While reset is held, the pins show the reset fetch address 0x4000, so the first fetch is visible at once.

Top module: `mem_bus_if`

## Requirements
- R1: While `rst_n` is low, `pad_shared_o` is 0x00, `pad_hi_o` is 0xC0 (write strobe high, high address 0x40), and `dac_level` is 0x00.
- R2: Out of reset, in any cycle that is not a store in phase 2 or 3, `pad_shared_o` equals `cpu_addr[7:0]` and `pad_hi_o[6:0]` equals `cpu_addr[14:8]`.
- R3: When `cpu_wr` is 1 and `cpu_phase` is 2 (execute) or 3 (writeback), `pad_shared_o` equals `cpu_wdata`. `pad_hi_o[6:0]` still equals `cpu_addr[14:8]`. In phases 0 and 1 a store still shows the address, as in R2.
- R4: The active-low write strobe `pad_hi_o[7]` is 0 exactly when `cpu_wr` is 1, `cpu_phase` is 3 and `cpu_addr[15]` is 0. Otherwise it is 1, including for stores to the ROM region and to 0xFF00.
- R5: When `cpu_addr[15]` is 0, `cpu_rdata` equals `pad_din` in the same cycle.
- R6: When `cpu_addr[15]` is 1, `cpu_rdata` equals ROM byte i = `cpu_addr[7:0]`, where byte(i) = ((i*29 + 0x3C) mod 256) XOR {i[3:0], i[7:4]}. The ROM repeats through the whole upper half.
- R7: A store in phase 3 to address 0xFF00 loads `cpu_wdata` into `dac_level` at the next rising clock edge. Every other cycle leaves `dac_level` unchanged, including a store to 0xFF00 in phase 2 and a phase-3 store to 0xFF01.
- R8: A read of 0xFF00 returns ROM byte 0x00, never the value held in `dac_level`.
- R9: `pad_shared_oe` is 0xFF in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU store byte |
| cpu_wr | input | 1 | Current instruction is a memory store |
| cpu_phase | input | 2 | Cycle phase: 0 fetch, 1 decode, 2 execute, 3 writeback |
| cpu_rdata | output | 8 | Read byte returned to the CPU (combinational) |
| pad_din | input | 8 | Input pins carrying external read data |
| pad_shared_o | output | 8 | Shared pins: low address byte or store byte |
| pad_shared_oe | output | 8 | Output enable for the shared pins |
| pad_hi_o | output | 8 | Bits [6:0] are address bits [14:8]; bit 7 is the write strobe, active low |
| dac_level | output | 8 | Audio level register value |

## Verification
A writeback-phase store to 0xFF00 does two things in one cycle. It loads the audio register, and it presents an upper-half address, so the read mux must return ROM byte 0x00. In that same cycle the write strobe must stay high and the shared pins must carry the store byte. The bench drives that exact cycle and checks all four results. It compares the read byte with the ROM formula, expects the strobe high and the store byte on the pins, and expects the new level only from the following cycle. A phase-2 store to 0xFF00 and a phase-3 store to 0xFF01 go through the same path and must leave the level unchanged.

// File: rtl/membus_pkg.sv
package membus_pkg;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_EXEC   = 2'd2,
    PH_WBACK  = 2'd3
  } bus_phase_e;

  typedef enum logic [1:0] {
    TGT_EXT = 2'd0,
    TGT_ROM = 2'd1,
    TGT_DAC = 2'd2
  } bus_target_e;

  // Test ROM content, computed rather than tabulated.
  function automatic logic [7:0] rom_byte(input logic [7:0] idx);
    logic [7:0] mixed;
    mixed = (idx * 8'd29) + 8'h3C;
    return mixed ^ {idx[3:0], idx[7:4]};
  endfunction

endpackage

// File: rtl/membus_decode.sv
module membus_decode
  import membus_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] DAC_ADDR = 16'hFF00
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [1:0]        phase,
  output bus_target_e       target,
  output logic              drive_data,
  output logic              ext_we,
  output logic              dac_load
);
  bus_phase_e ph;
  logic       wb_store;

  always_comb begin
    ph         = bus_phase_e'(phase);
    drive_data = wr && (ph == PH_EXEC || ph == PH_WBACK);
    wb_store   = wr && (ph == PH_WBACK);
    if (!addr[ADDR_W-1])
      target = TGT_EXT;
    else if (addr == DAC_ADDR[ADDR_W-1:0])
      target = TGT_DAC;
    else
      target = TGT_ROM;
    ext_we   = wb_store && (target == TGT_EXT);
    dac_load = wb_store && (target == TGT_DAC);
  end
endmodule

// File: rtl/membus_rom.sv
module membus_rom
  import membus_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] contents [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign contents[g] = DATA_W'(rom_byte(8'(g)));
  end

  assign q = contents[idx];
endmodule

// File: rtl/membus_pads.sv
module membus_pads #(
  parameter int          DATA_W   = 8,
  parameter int          HI_W     = 7,
  parameter logic [15:0] RESET_PC = 16'h4000
) (
  input  logic              rst_n,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic [HI_W-1:0]   addr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drive_data,
  input  logic              ext_we,
  output logic [DATA_W-1:0] shared_o,
  output logic [DATA_W-1:0] shared_oe,
  output logic [HI_W:0]     hi_o
);
  localparam logic [DATA_W-1:0] RST_LO = RESET_PC[DATA_W-1:0];
  localparam logic [HI_W-1:0]   RST_HI = RESET_PC[DATA_W +: HI_W];

  assign shared_oe = '1;

  always_comb begin
    if (!rst_n) begin
      shared_o = RST_LO;
      hi_o     = {1'b1, RST_HI};
    end else begin
      shared_o = drive_data ? wdata : addr_lo;
      hi_o     = {~ext_we, addr_hi};
    end
  end
endmodule

// File: rtl/membus_dac.sv
module membus_dac #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      level <= '0;
    else if (load)
      level <= din;
  end
endmodule

// File: rtl/mem_bus_if.sv
module mem_bus_if
  import membus_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          ROM_IDX  = 8,
  parameter logic [15:0] DAC_ADDR = 16'hFF00,
  parameter logic [15:0] RESET_PC = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_phase,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] pad_din,
  output logic [DATA_W-1:0] pad_shared_o,
  output logic [DATA_W-1:0] pad_shared_oe,
  output logic [DATA_W-1:0] pad_hi_o,
  output logic [DATA_W-1:0] dac_level
);
  localparam int HI_W = ADDR_W - 1 - DATA_W;

  bus_target_e       target;
  logic              drive_data;
  logic              ext_we;
  logic              dac_load;
  logic [DATA_W-1:0] rom_q;

  membus_decode #(.ADDR_W(ADDR_W), .DAC_ADDR(DAC_ADDR)) u_decode (
    .addr       (cpu_addr),
    .wr         (cpu_wr),
    .phase      (cpu_phase),
    .target     (target),
    .drive_data (drive_data),
    .ext_we     (ext_we),
    .dac_load   (dac_load)
  );

  membus_rom #(.IDX_W(ROM_IDX), .DATA_W(DATA_W)) u_rom (
    .idx (cpu_addr[ROM_IDX-1:0]),
    .q   (rom_q)
  );

  membus_pads #(.DATA_W(DATA_W), .HI_W(HI_W), .RESET_PC(RESET_PC)) u_pads (
    .rst_n      (rst_n),
    .addr_lo    (cpu_addr[DATA_W-1:0]),
    .addr_hi    (cpu_addr[ADDR_W-2:DATA_W]),
    .wdata      (cpu_wdata),
    .drive_data (drive_data),
    .ext_we     (ext_we),
    .shared_o   (pad_shared_o),
    .shared_oe  (pad_shared_oe),
    .hi_o       (pad_hi_o)
  );

  membus_dac #(.DATA_W(DATA_W)) u_dac (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (dac_load),
    .din   (cpu_wdata),
    .level (dac_level)
  );

  // The audio register is write-only: a read of its address returns ROM data.
  assign cpu_rdata = (target == TGT_EXT) ? pad_din : rom_q;
endmodule

// File: rtl/mem_bus_if_chk.sv
module mem_bus_if_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_wr,
  input logic [1:0]  cpu_phase,
  input logic [7:0]  cpu_rdata,
  input logic [7:0]  pad_din,
  input logic [7:0]  pad_shared_o,
  input logic [7:0]  pad_hi_o,
  input logic [7:0]  dac_level
);
  logic store_late, wb_ext, dac_hit;
  assign store_late = cpu_wr && cpu_phase[1];
  assign wb_ext     = cpu_wr && (cpu_phase == 2'd3) && !cpu_addr[15];
  assign dac_hit    = cpu_wr && (cpu_phase == 2'd3) && (cpu_addr == 16'hFF00);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_pins: assert (pad_shared_o == 8'h00 && pad_hi_o == 8'hC0 && dac_level == 8'h00)
        else $error("R1 reset pin state wrong");
    end
  end

  a_r2_addr_on_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !store_late |-> (pad_shared_o == cpu_addr[7:0] && pad_hi_o[6:0] == cpu_addr[14:8]));

  a_r3_data_on_pins: assert property (@(posedge clk) disable iff (!rst_n)
    store_late |-> (pad_shared_o == cpu_wdata && pad_hi_o[6:0] == cpu_addr[14:8]));

  a_r4_strobe_only_ext: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_hi_o[7] |-> wb_ext);

  a_r4_strobe_when_due: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ext |-> !pad_hi_o[7]);

  a_r5_ext_read: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[15] |-> cpu_rdata == pad_din);

  a_r7_dac_load: assert property (@(posedge clk) disable iff (!rst_n)
    dac_hit |=> dac_level == $past(cpu_wdata));

  a_r7_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_hit |=> $stable(dac_level));
endmodule

bind mem_bus_if mem_bus_if_chk u_chk (.*);

// File: tb/mem_bus_if_tb_top.sv
module mem_bus_if_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_wr;
  logic [1:0]  cpu_phase;
  logic [7:0]  cpu_rdata;
  logic [7:0]  pad_din;
  logic [7:0]  pad_shared_o;
  logic [7:0]  pad_shared_oe;
  logic [7:0]  pad_hi_o;
  logic [7:0]  dac_level;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mem_bus_if dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .cpu_wr        (cpu_wr),
    .cpu_phase     (cpu_phase),
    .cpu_rdata     (cpu_rdata),
    .pad_din       (pad_din),
    .pad_shared_o  (pad_shared_o),
    .pad_shared_oe (pad_shared_oe),
    .pad_hi_o      (pad_hi_o),
    .dac_level     (dac_level)
  );

  typedef struct {
    logic [7:0] rd;
    logic [7:0] sh;
    logic [7:0] oe;
    logic [7:0] hi;
    logic [7:0] dac;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  int         total = 0;
  int         bad   = 0;
  bit         done  = 0;
  logic [7:0] dac_m = 8'h00;

  // ROM byte per R6
  function automatic logic [7:0] rom_ref(input logic [7:0] i);
    logic [7:0] p;
    p = (i * 8'd29) + 8'h3C;
    return p ^ {i[3:0], i[7:4]};
  endfunction

  task automatic cyc(input bit rst, input logic [15:0] a, input logic [7:0] wd,
                     input bit wr, input logic [1:0] ph, input logic [7:0] din,
                     input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    rst_n     = !rst;
    cpu_addr  = a;
    cpu_wdata = wd;
    cpu_wr    = wr;
    cpu_phase = ph;
    pad_din   = din;
    if (rst) dac_m = 8'h00;
    e.oe = 8'hFF;
    if (rst) begin
      e.sh = 8'h00;
      e.hi = 8'hC0;
    end else begin
      e.sh = (wr && ph >= 2'd2) ? wd : a[7:0];
      e.hi = {!(wr && ph == 2'd3 && !a[15]), a[14:8]};
    end
    e.rd  = a[15] ? rom_ref(a[7:0]) : din;
    e.dac = dac_m;
    e.tag = tag;
    sb_q.push_back(e);
    if (!rst && wr && ph == 2'd3 && a == 16'hFF00) dac_m = wd;
  endtask

  task automatic cmp(input string tag, input string f, input logic [7:0] act,
                     input logic [7:0] exp, inout bit ok);
    if (act !== exp) begin
      ok = 0;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, f, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      bit ok;
      e  = sb_q.pop_front();
      ok = 1;
      cmp(e.tag, "rdata", cpu_rdata, e.rd, ok);
      cmp(e.tag, "shared", pad_shared_o, e.sh, ok);
      cmp(e.tag, "oe(R9)", pad_shared_oe, e.oe, ok);
      cmp(e.tag, "hi", pad_hi_o, e.hi, ok);
      cmp(e.tag, "dac", dac_level, e.dac, ok);
      total++;
      if (!ok) bad++;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_addr = 16'h1234; cpu_wdata = 8'h00;
    cpu_wr = 1'b0; cpu_phase = 2'd0; pad_din = 8'h00;
    // R1: reset state, with noise on the CPU side
    cyc(1, 16'h1234, 8'h11, 0, 2'd0, 8'h5A, "R1 reset idle");
    cyc(1, 16'hFF00, 8'h77, 1, 2'd3, 8'h5A, "R1 reset with store to dac");
    cyc(1, 16'h2010, 8'h99, 1, 2'd3, 8'h00, "R1 reset with ext store");
    // R2/R5: fetch at reset vector and other external reads
    cyc(0, 16'h4000, 8'h00, 0, 2'd0, 8'hA5, "R2 R5 first fetch");
    cyc(0, 16'h7FFF, 8'h00, 0, 2'd1, 8'h3C, "R2 R5 top of ext");
    cyc(0, 16'h0000, 8'hEE, 0, 2'd2, 8'hC3, "R2 read in exec phase");
    cyc(0, 16'h2A55, 8'hEE, 0, 2'd3, 8'h81, "R2 read in wb phase");
    // R6/R8: ROM reads and mirroring
    cyc(0, 16'h8000, 8'h00, 0, 2'd0, 8'hFF, "R6 rom base");
    cyc(0, 16'h80FF, 8'h00, 0, 2'd0, 8'hFF, "R6 rom last");
    cyc(0, 16'hC012, 8'h00, 0, 2'd1, 8'h00, "R6 rom mirror");
    cyc(0, 16'hFF00, 8'h00, 0, 2'd0, 8'h00, "R8 read of dac address");
    // R3/R4: external store through all phases
    cyc(0, 16'h2013, 8'hB7, 1, 2'd0, 8'h00, "R3 store fetch shows addr");
    cyc(0, 16'h2013, 8'hB7, 1, 2'd1, 8'h00, "R3 store decode shows addr");
    cyc(0, 16'h2013, 8'hB7, 1, 2'd2, 8'h00, "R3 store exec shows data");
    cyc(0, 16'h2013, 8'hB7, 1, 2'd3, 8'h00, "R4 R3 store wb strobe low");
    cyc(0, 16'h8055, 8'h42, 1, 2'd3, 8'h00, "R4 store to rom no strobe");
    // R7/R8: audio register
    cyc(0, 16'hFF00, 8'h6D, 1, 2'd2, 8'h00, "R7 exec store no load");
    cyc(0, 16'hFF00, 8'h9E, 1, 2'd3, 8'h00, "R7 R8 R4 wb store load cycle");
    cyc(0, 16'hFF00, 8'h00, 0, 2'd0, 8'h00, "R7 R8 level visible read rom");
    cyc(0, 16'hFF01, 8'h13, 1, 2'd3, 8'h00, "R7 store to ff01 no load");
    cyc(0, 16'h1000, 8'h27, 1, 2'd3, 8'h44, "R7 ext store keeps level");
    cyc(0, 16'hFF00, 8'h00, 1, 2'd3, 8'h00, "R7 load zero");
    cyc(0, 16'hFF00, 8'hFF, 1, 2'd3, 8'h00, "R7 load ff");
    cyc(0, 16'h4001, 8'h00, 0, 2'd0, 8'h12, "R7 level ff held");
    // R1: reset again mid-run clears level
    cyc(1, 16'h4001, 8'h00, 0, 2'd0, 8'h12, "R1 mid-run reset");
    cyc(0, 16'h4000, 8'h00, 0, 2'd0, 8'h34, "R1 R2 fetch after reset");
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule